// File: doc/BRIEF.md
# USB PHY Control Register File with Bit-Set, Bit-Clear and Bit-Flip Aliases

This block holds the 32-bit control and status words of a USB physical-layer macro and serves them on a plain word-wide bus. Software reaches each writable control word through four neighbouring word addresses. The first address reads and writes the word as a whole. The other three change only the bits marked in the write data: one sets them, one clears them, one inverts them. This lets a driver change single fields without a read-modify-write sequence. A read at any of the four addresses returns the word itself.

Two reset levels exist. The asynchronous power-on reset loads every word. A soft reset loads only the power-down, transmit, receive and control words and leaves the rest alone. Software starts a soft reset by writing the reset bit of the control word through the whole-word address or the bit-set address. Through the bit-flip address, it starts one only when the flip leaves that bit at one. Read data is registered and comes back one cycle after the request, together with a valid strobe.

Top module: `phy_alias_regfile`

## Requirements
- R1: After power-on reset the words read: power-down (byte 0x00) 0x001e1c00, transmit (0x10) 0x10060607, receive (0x20) 0, control (0x30) 0xc0200000, status (0x40) 0, debug (0x50) 0x7f180000, debug-status (0x60) 0, debug1 (0x70) 0x00001000, version (0x80) 0x04020000.
- R2: A write to the base byte address of a writable word (0x00, 0x10, 0x20, 0x30, 0x40, 0x50, 0x70) replaces the word with the write data.
- R3: A write at base+0x4 ORs the data into the word.
- R4: A write at base+0x8 clears the word's bits that are one in the data.
- R5: A write at base+0xC XORs the data into the word.
- R6: A read at base+0x4, base+0x8 or base+0xC returns the current value of the word at base.
- R7: The status word has no aliases: bytes 0x44, 0x48 and 0x4C read as zero, and writes to them leave status unchanged.
- R8: The debug-status word (0x60) and the version word (0x80) ignore all writes.
- R9: Unmapped words (any byte address from 0x90 upward, and the alias slots of the read-only words) read as zero, and writes to them change nothing.
- R10: A write to 0x30 or 0x34 whose data has bit 31 set loads power-down, transmit, receive and control with their R1 values, in place of the written value, and leaves every other word unchanged. The same writes with bit 31 clear start no soft reset.
- R11: A write to 0x3C with data bit 31 set starts a soft reset only when control bit 31 was zero before the write. A write to 0x38 never starts one.
- R12: bus_rvalid is high exactly one cycle after a cycle with bus_ren high, with bus_rdata holding the word as it was before any write in that same request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | 10 | Word address, byte address bits [11:2] |
| bus_wen | input | 1 | Write request |
| bus_ren | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_ren |

## Verification
The hardest case to reach is the bit-flip write to the control word, because whether it starts a soft reset depends on the control word's state before the write. The stimulus first clears control bit 31 through the bit-clear alias, which must not reset anything. It then plants a marker value in the receive word and flips bit 31 twice. The first flip must wipe the marker, and the second, starting from a one, must keep a newly planted marker. The marker in the receive word is what shows, at the ports, whether a soft reset happened.

// File: rtl/phy_alias_pkg.sv
package phy_alias_pkg;

   typedef enum logic [1:0] {
      OP_BASE = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2,
      OP_TOG  = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      K_CONST,
      K_PLAIN,
      K_ALIAS
   } kind_e;

   localparam int NREG    = 9;
   localparam int R_PWD   = 0;
   localparam int R_TX    = 1;
   localparam int R_RX    = 2;
   localparam int R_CTRL  = 3;
   localparam int R_STAT  = 4;
   localparam int R_DBG   = 5;
   localparam int R_DBGS  = 6;
   localparam int R_DBG1  = 7;
   localparam int R_VER   = 8;

   function automatic kind_e reg_kind(int idx);
      case (idx)
         R_STAT:        return K_PLAIN;
         R_DBGS, R_VER: return K_CONST;
         default:       return K_ALIAS;
      endcase
   endfunction

   function automatic logic in_soft_set(int idx);
      return (idx == R_PWD) || (idx == R_TX) || (idx == R_RX) || (idx == R_CTRL);
   endfunction

   function automatic logic [31:0] soft_val(int idx);
      case (idx)
         R_PWD:   return 32'h001e_1c00;
         R_TX:    return 32'h1006_0607;
         R_CTRL:  return 32'hc020_0000;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic logic [31:0] por_val(int idx);
      case (idx)
         R_DBG:   return 32'h7f18_0000;
         R_DBG1:  return 32'h0000_1000;
         R_VER:   return 32'h0402_0000;
         default: return soft_val(idx);
      endcase
   endfunction

endpackage

// File: rtl/pa_decode.sv
module pa_decode
   import phy_alias_pkg::*;
#(
   parameter int WW = 10
) (
   input  logic [WW-1:0]   widx,
   output op_e             op,
   output logic [NREG-1:0] wr_hit,
   output logic [NREG-1:0] rd_hit
);

   localparam int GW = WW - 2;

   logic [GW-1:0] grp;

   assign grp = widx[WW-1:2];
   assign op  = op_e'(widx[1:0]);

   for (genvar g = 0; g < NREG; g++) begin : g_slot
      localparam kind_e KIND = reg_kind(g);
      logic match;
      assign match = (grp == GW'(g));
      if (KIND == K_ALIAS) begin : g_alias
         assign wr_hit[g] = match;
         assign rd_hit[g] = match;
      end else if (KIND == K_PLAIN) begin : g_plain
         assign wr_hit[g] = match && (op == OP_BASE);
         assign rd_hit[g] = match && (op == OP_BASE);
      end else begin : g_const
         assign wr_hit[g] = 1'b0;
         assign rd_hit[g] = match && (op == OP_BASE);
      end
   end

endmodule

// File: rtl/pa_reg.sv
module pa_reg
   import phy_alias_pkg::*;
#(
   parameter int            DW   = 32,
   parameter logic [DW-1:0] POR  = '0,
   parameter logic [DW-1:0] SOFT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  op_e           op,
   input  logic [DW-1:0] wdata,
   input  logic          load_soft,
   output logic [DW-1:0] q
);

   logic [DW-1:0] upd;

   always_comb begin
      case (op)
         OP_SET:  upd = q | wdata;
         OP_CLR:  upd = q & ~wdata;
         OP_TOG:  upd = q ^ wdata;
         default: upd = wdata;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= POR;
      end else if (load_soft) begin
         q <= SOFT;
      end else if (we) begin
         q <= upd;
      end
   end

endmodule

// File: rtl/phy_alias_regfile.sv
module phy_alias_regfile
   import phy_alias_pkg::*;
#(
   parameter int AW       = 12,
   parameter int DW       = 32,
   parameter int SRST_BIT = 31
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:2] bus_addr,
   input  logic          bus_wen,
   input  logic          bus_ren,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          bus_rvalid
);

   localparam int WW = AW - 2;

   if (AW < 8 || AW > 16) begin : g_bad_aw
      $error("phy_alias_regfile: AW must be in 8..16");
   end
   if (DW < 32) begin : g_bad_dw
      $error("phy_alias_regfile: DW must be at least 32");
   end
   if (SRST_BIT >= DW) begin : g_bad_bit
      $error("phy_alias_regfile: SRST_BIT outside data word");
   end

   op_e             op;
   logic [NREG-1:0] wr_hit;
   logic [NREG-1:0] rd_hit;
   logic [DW-1:0]   reg_q [NREG];
   logic [DW-1:0]   rmux;
   logic            ctrl_wr;
   logic            ctrl_bit_after_tog;
   logic            soft_fire;

   pa_decode #(.WW(WW)) u_dec (
      .widx   (bus_addr),
      .op     (op),
      .wr_hit (wr_hit),
      .rd_hit (rd_hit)
   );

   assign ctrl_wr            = bus_wen && wr_hit[R_CTRL];
   assign ctrl_bit_after_tog = reg_q[R_CTRL][SRST_BIT] ^ bus_wdata[SRST_BIT];
   assign soft_fire = ctrl_wr && bus_wdata[SRST_BIT] &&
                      ((op == OP_BASE) || (op == OP_SET) ||
                       ((op == OP_TOG) && ctrl_bit_after_tog));

   for (genvar g = 0; g < NREG; g++) begin : g_word
      localparam kind_e         KIND  = reg_kind(g);
      localparam logic [DW-1:0] POR_V = DW'(por_val(g));
      localparam logic [DW-1:0] SFT_V = DW'(soft_val(g));
      localparam bit            SOFT_MEMBER = in_soft_set(g);
      if (KIND == K_CONST) begin : g_ro
         assign reg_q[g] = POR_V;
      end else begin : g_rw
         logic ld;
         if (SOFT_MEMBER) begin : g_sr
            assign ld = soft_fire;
         end else begin : g_nosr
            assign ld = 1'b0;
         end
         pa_reg #(.DW(DW), .POR(POR_V), .SOFT(SFT_V)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (bus_wen && wr_hit[g]),
            .op        (op),
            .wdata     (bus_wdata),
            .load_soft (ld),
            .q         (reg_q[g])
         );
      end
   end

   always_comb begin
      rmux = '0;
      for (int g = 0; g < NREG; g++) begin
         if (rd_hit[g]) rmux = rmux | reg_q[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_ren;
         if (bus_ren) bus_rdata <= rmux;
      end
   end

endmodule

// File: rtl/phy_alias_chk.sv
module phy_alias_chk
   import phy_alias_pkg::*;
#(
   parameter int AW       = 12,
   parameter int DW       = 32,
   parameter int SRST_BIT = 31
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:2] addr,
   input logic          wen,
   input logic          ren,
   input logic [DW-1:0] wdata,
   input logic          rvalid,
   input logic [DW-1:0] pwd_q,
   input logic [DW-1:0] tx_q,
   input logic [DW-1:0] ctrl_q,
   input logic [DW-1:0] stat_q
);

   localparam int WW = AW - 2;

   p_soft_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && addr == WW'(12) && wdata[SRST_BIT]) |=>
      (pwd_q == DW'(soft_val(R_PWD)) && ctrl_q == DW'(soft_val(R_CTRL))));

   p_clr_no_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && addr == WW'(14)) |=> $stable(pwd_q));

   p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && addr == WW'(5)) |=> (tx_q == ($past(tx_q) | $past(wdata))));

   p_stat_alias_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && addr[AW-1:4] == (AW-4)'(R_STAT) && addr[3:2] != 2'd0) |=> $stable(stat_q));

   p_rvalid_hi_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ren |=> rvalid);

   p_rvalid_lo_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !ren |=> !rvalid);

endmodule

bind phy_alias_regfile phy_alias_chk #(.AW(AW), .DW(DW), .SRST_BIT(SRST_BIT)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr   (bus_addr),
   .wen    (bus_wen),
   .ren    (bus_ren),
   .wdata  (bus_wdata),
   .rvalid (bus_rvalid),
   .pwd_q  (reg_q[0]),
   .tx_q   (reg_q[1]),
   .ctrl_q (reg_q[3]),
   .stat_q (reg_q[4])
);

// File: tb/sim_phy_alias_regfile.sv
module sim_phy_alias_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:2] bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic        bus_ren = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   phy_alias_regfile u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wen    (bus_wen),
      .bus_ren    (bus_ren),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid)
   );

   typedef struct packed {
      logic        wr;
      logic [11:0] wa;
      logic [31:0] wd;
      logic [11:0] ra;
      logic [31:0] ex;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 44;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 12'h000, 32'h0, 12'h000, 32'h001e1c00, 4'd1},  // R1
      '{1'b0, 12'h000, 32'h0, 12'h010, 32'h10060607, 4'd1},  // R1
      '{1'b0, 12'h000, 32'h0, 12'h020, 32'h00000000, 4'd1},  // R1
      '{1'b0, 12'h000, 32'h0, 12'h030, 32'hc0200000, 4'd1},  // R1
      '{1'b0, 12'h000, 32'h0, 12'h040, 32'h00000000, 4'd1},  // R1
      '{1'b0, 12'h000, 32'h0, 12'h050, 32'h7f180000, 4'd1},  // R1
      '{1'b0, 12'h000, 32'h0, 12'h060, 32'h00000000, 4'd1},  // R1
      '{1'b0, 12'h000, 32'h0, 12'h070, 32'h00001000, 4'd1},  // R1
      '{1'b0, 12'h000, 32'h0, 12'h080, 32'h04020000, 4'd1},  // R1
      '{1'b1, 12'h010, 32'h000000f0, 12'h010, 32'h000000f0, 4'd2},  // R2
      '{1'b1, 12'h014, 32'h0f00000f, 12'h010, 32'h0f0000ff, 4'd3},  // R3
      '{1'b1, 12'h018, 32'h000000f0, 12'h010, 32'h0f00000f, 4'd4},  // R4
      '{1'b1, 12'h01c, 32'hff000001, 12'h010, 32'hf000000e, 4'd5},  // R5
      '{1'b0, 12'h000, 32'h0, 12'h014, 32'hf000000e, 4'd6},  // R6
      '{1'b0, 12'h000, 32'h0, 12'h018, 32'hf000000e, 4'd6},  // R6
      '{1'b0, 12'h000, 32'h0, 12'h01c, 32'hf000000e, 4'd6},  // R6
      '{1'b1, 12'h074, 32'h00000003, 12'h070, 32'h00001003, 4'd3},  // R3
      '{1'b1, 12'h040, 32'h12345678, 12'h040, 32'h12345678, 4'd2},  // R2
      '{1'b1, 12'h044, 32'hffffffff, 12'h040, 32'h12345678, 4'd7},  // R7
      '{1'b0, 12'h000, 32'h0, 12'h044, 32'h00000000, 4'd7},  // R7
      '{1'b1, 12'h080, 32'h00000000, 12'h080, 32'h04020000, 4'd8},  // R8
      '{1'b1, 12'h060, 32'hffffffff, 12'h060, 32'h00000000, 4'd8},  // R8
      '{1'b1, 12'h090, 32'hdeadbeef, 12'h090, 32'h00000000, 4'd9},  // R9
      '{1'b0, 12'h000, 32'h0, 12'hffc, 32'h00000000, 4'd9},  // R9
      '{1'b1, 12'h020, 32'h0000abcd, 12'h020, 32'h0000abcd, 4'd2},  // R2
      '{1'b1, 12'h030, 32'h80000001, 12'h030, 32'hc0200000, 4'd10}, // R10
      '{1'b0, 12'h000, 32'h0, 12'h020, 32'h00000000, 4'd10}, // R10
      '{1'b0, 12'h000, 32'h0, 12'h010, 32'h10060607, 4'd10}, // R10
      '{1'b0, 12'h000, 32'h0, 12'h040, 32'h12345678, 4'd10}, // R10
      '{1'b0, 12'h000, 32'h0, 12'h070, 32'h00001003, 4'd10}, // R10
      '{1'b1, 12'h020, 32'h00000055, 12'h020, 32'h00000055, 4'd2},  // R2
      '{1'b1, 12'h038, 32'h80000000, 12'h030, 32'h40200000, 4'd11}, // R11
      '{1'b0, 12'h000, 32'h0, 12'h020, 32'h00000055, 4'd11}, // R11
      '{1'b1, 12'h03c, 32'h80000010, 12'h020, 32'h00000000, 4'd11}, // R11
      '{1'b0, 12'h000, 32'h0, 12'h030, 32'hc0200000, 4'd11}, // R11
      '{1'b1, 12'h020, 32'h00000077, 12'h020, 32'h00000077, 4'd2},  // R2
      '{1'b1, 12'h03c, 32'h80000010, 12'h030, 32'h40200010, 4'd11}, // R11
      '{1'b0, 12'h000, 32'h0, 12'h020, 32'h00000077, 4'd11}, // R11
      '{1'b1, 12'h034, 32'h80000000, 12'h020, 32'h00000000, 4'd10}, // R10
      '{1'b0, 12'h000, 32'h0, 12'h030, 32'hc0200000, 4'd10}, // R10
      '{1'b1, 12'h034, 32'h00000004, 12'h030, 32'hc0200004, 4'd3},  // R3
      '{1'b1, 12'h000, 32'h00000000, 12'h000, 32'h00000000, 4'd2},  // R2
      '{1'b1, 12'h030, 32'h00000001, 12'h000, 32'h00000000, 4'd10}, // R10
      '{1'b0, 12'h000, 32'h0, 12'h030, 32'h00000001, 4'd2}   // R2
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic wr_word(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a[11:2];
      bus_wdata = d;
      bus_wen   = 1'b1;
      @(negedge clk);
      bus_wen   = 1'b0;
   endtask

   task automatic rd_word(input logic [11:0] a, output logic [31:0] d, output logic v);
      @(negedge clk);
      bus_addr = a[11:2];
      bus_ren  = 1'b1;
      @(negedge clk);
      bus_ren  = 1'b0;
      d = bus_rdata;
      v = bus_rvalid;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic        v;
      repeat (3) @(negedge clk);
      check("R12 rvalid in reset", {31'd0, bus_rvalid}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) wr_word(VEC[i].wa, VEC[i].wd);
         rd_word(VEC[i].ra, d, v);
         check($sformatf("R%0d vector %0d valid", VEC[i].req, i), {31'd0, v}, 32'd1);
         check($sformatf("R%0d vector %0d data", VEC[i].req, i), d, VEC[i].ex);
      end

      // R12: read and write of status in one cycle returns the old value
      @(negedge clk);
      bus_addr  = 10'h010;
      bus_wdata = 32'haaaa5555;
      bus_wen   = 1'b1;
      bus_ren   = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
      bus_ren = 1'b0;
      check("R12 same-cycle valid", {31'd0, bus_rvalid}, 32'd1);
      check("R12 same-cycle old data", bus_rdata, 32'h12345678);
      @(negedge clk);
      check("R12 no request no valid", {31'd0, bus_rvalid}, 32'd0);
      rd_word(12'h040, d, v);
      check("R12 later read new data", d, 32'haaaa5555);

      // R1: power-on reset mid-run restores everything
      wr_word(12'h070, 32'h0);
      wr_word(12'h020, 32'h99);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd_word(12'h030, d, v);
      check("R1 ctrl after reset", d, 32'hc0200000);
      rd_word(12'h040, d, v);
      check("R1 status after reset", d, 32'h00000000);
      rd_word(12'h070, d, v);
      check("R1 debug1 after reset", d, 32'h00001000);
      rd_word(12'h020, d, v);
      check("R1 rx after reset", d, 32'h00000000);

      finish_run();
   end

endmodule